// File: doc/BRIEF.md
# Receive Message Queue with Release-Driven Head

This block buffers received frames between a protocol engine and software. The engine pushes each finished frame with a one-cycle strobe. Software never sees the storage directly. It sees one head frame, the oldest stored message, together with a 2-bit pending count and two sticky flags.

When software has consumed the head, it writes the release bit. The next stored message then becomes the head, and the release bit reads back as 1 for one cycle. A release while nothing is pending is ignored. Storage holds three frames. A frame that arrives while all three slots are occupied is dropped and raises the overrun flag. The full flag latches when the third slot fills. Software clears both flags by writing 1 to them.

A 32-bit register view packs the count, the flags and the release bit for a software read port.

Top module: `rx_fifo_rel`

## Requirements
- R1: After reset the pending count, full flag, overrun flag and release bit are 0, the head frame is all zeros and the register view reads 0.
- R2: Each accepted push raises the pending count by one, up to 3, and frames leave in the order they arrived.
- R3: A release write while the count is nonzero lowers the count by one and shows the next stored frame at the head one cycle later. Without a release, the head stays unchanged while the count is nonzero.
- R4: The release bit reads 1 in exactly the one cycle that follows a release write made while the count is nonzero, and reads 0 otherwise.
- R5: A release write while the count is 0 has no effect: the count stays 0, the head stays all zeros and the release bit stays 0.
- R6: The full flag sets when a push brings the count to 3. It stays set after releases and clears only on a clear-full write of 1. If the flag sets and is cleared in the same cycle, setting wins.
- R7: A push while the count is 3 and no release is written drops the incoming frame and keeps the stored frames and the count. It also sets the overrun flag, which stays set until a clear-overrun write of 1. If the flag sets and is cleared in the same cycle, setting wins.
- R8: A push and a release in the same cycle while the count is nonzero leave the count unchanged, move the head to the next frame and append the new frame at the tail. This also holds at count 3, where it sets the full flag and not the overrun flag.
- R9: In the register view, bits 1:0 hold the count, bit 2 reads 0, bit 3 is the full flag, bit 4 the overrun flag, bit 5 the release bit, and bits 31:6 read 0.
- R10: While the count is 0 the head frame reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | One-cycle strobe that stores a received frame |
| push_frame_i | input | FRAME_W | Frame that comes with the push |
| rel_wr_i | input | 1 | Software writes 1 to the release bit |
| clr_full_i | input | 1 | Software writes 1 to the full flag (clears it) |
| clr_ovr_i | input | 1 | Software writes 1 to the overrun flag (clears it) |
| head_frame_o | output | FRAME_W | Oldest pending frame, or zeros when empty |
| pend_cnt_o | output | 2 | Number of pending frames |
| full_o | output | 1 | Sticky full flag |
| ovr_o | output | 1 | Sticky overrun flag |
| rel_o | output | 1 | Release bit readback |
| reg_o | output | 32 | Packed register view |

## Verification
Some rules hold on every cycle and are checked as properties: the count bound, head stability without a release, the one-cycle release pulse and its cause, empty releases being ignored, flag stickiness, overrun on a push into a full queue, the count holding on a combined push and release, and a zero head when empty. Other behaviour spans several cycles, and only the bench's scenarios, compared cycle by cycle against a queue model, can show it. That includes arrival order across pointer wrap, the stored frames surviving an overrun, the priority of a flag that is set and cleared in the same cycle, and the packed register layout.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned REG_CNT_W = 2;
  localparam int unsigned CNT_LSB   = 0;
  localparam int unsigned FULL_BIT  = 3;
  localparam int unsigned OVR_BIT   = 4;
  localparam int unsigned REL_BIT   = 5;

  typedef struct packed {
    logic full;
    logic ovr;
    logic rel;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH   = 3,
  parameter int unsigned FRAME_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FRAME_W-1:0] wr_data_i,
  input  logic               rd_adv_i,
  input  logic               empty_i,
  output logic [FRAME_W-1:0] head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
  logic [FRAME_W-1:0] slot_q [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i)  wr_ptr_q <= bump(wr_ptr_q);
      if (rd_adv_i) rd_ptr_q <= bump(rd_ptr_q);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[i] <= '0;
      else if (wr_en_i && wr_ptr_q == PTR_W'(i))     slot_q[i] <= wr_data_i;
    end
  end

  assign head_o = empty_i ? '0 : slot_q[rd_ptr_q];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             rel_wr_i,
  input  logic             clr_full_i,
  input  logic             clr_ovr_i,
  output logic [CNT_W-1:0] cnt_o,
  output rxf_flags_t       flags_o,
  output logic             push_acc_o,
  output logic             pop_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  rxf_flags_t       flg_q, flg_d;
  logic             do_rel, accept, drop;

  assign empty_o = (cnt_q == '0);
  assign do_rel  = rel_wr_i && !empty_o;
  // a same-cycle release frees a slot for the push
  assign accept  = push_i && ((cnt_q != CAP) || do_rel);
  assign drop    = push_i && !accept;

  always_comb begin
    unique case ({accept, do_rel})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    flg_d.rel  = do_rel;
    // set has priority over a clear in the same cycle
    flg_d.full = (accept && cnt_d == CAP) ? 1'b1 : (clr_full_i ? 1'b0 : flg_q.full);
    flg_d.ovr  = drop ? 1'b1 : (clr_ovr_i ? 1'b0 : flg_q.ovr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      flg_q <= flg_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign flags_o    = flg_q;
  assign push_acc_o = accept;
  assign pop_o      = do_rel;
endmodule

// File: rtl/rxf_regview.sv
module rxf_regview
  import rxf_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic             [CNT_W-1:0] cnt_i,
  input  rxf_flags_t                   flags_i,
  output logic             [REG_W-1:0] reg_o
);
  always_comb begin
    reg_o = '0;
    reg_o[CNT_LSB +: REG_CNT_W] = REG_CNT_W'(cnt_i);
    reg_o[FULL_BIT]             = flags_i.full;
    reg_o[OVR_BIT]              = flags_i.ovr;
    reg_o[REL_BIT]              = flags_i.rel;
  end
endmodule

// File: rtl/rx_fifo_rel.sv
module rx_fifo_rel
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH   = 3,
  parameter int unsigned FRAME_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [FRAME_W-1:0] push_frame_i,
  input  logic               rel_wr_i,
  input  logic               clr_full_i,
  input  logic               clr_ovr_i,
  output logic [FRAME_W-1:0] head_frame_o,
  output logic [1:0]         pend_cnt_o,
  output logic               full_o,
  output logic               ovr_o,
  output logic               rel_o,
  output logic [31:0]        reg_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;
  rxf_flags_t       flags;
  logic             push_acc, pop, empty;

  rxf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .rel_wr_i   (rel_wr_i),
    .clr_full_i (clr_full_i),
    .clr_ovr_i  (clr_ovr_i),
    .cnt_o      (cnt),
    .flags_o    (flags),
    .push_acc_o (push_acc),
    .pop_o      (pop),
    .empty_o    (empty)
  );

  rxf_store #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_acc),
    .wr_data_i (push_frame_i),
    .rd_adv_i  (pop),
    .empty_i   (empty),
    .head_o    (head_frame_o)
  );

  rxf_regview #(.CNT_W(CNT_W)) u_view (
    .cnt_i   (cnt),
    .flags_i (flags),
    .reg_o   (reg_o)
  );

  assign pend_cnt_o = 2'(cnt);
  assign full_o     = flags.full;
  assign ovr_o      = flags.ovr;
  assign rel_o      = flags.rel;
endmodule

// File: rtl/rx_fifo_rel_chk.sv
module rx_fifo_rel_chk #(
  parameter int unsigned DEPTH   = 3,
  parameter int unsigned FRAME_W = 40
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               push_i,
  input logic               rel_wr_i,
  input logic               clr_full_i,
  input logic               clr_ovr_i,
  input logic [FRAME_W-1:0] head_frame_o,
  input logic [1:0]         pend_cnt_o,
  input logic               full_o,
  input logic               ovr_o,
  input logic               rel_o
);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pend_cnt_o) <= DEPTH);

  a_r3_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt_o != 2'd0 && !rel_wr_i) |=> $stable(head_frame_o));

  a_r4_rel_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |-> ($past(rel_wr_i) && $past(pend_cnt_o) != 2'd0));

  a_r5_empty_rel_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_wr_i && pend_cnt_o == 2'd0) |=> !rel_o);

  a_r6_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_full_i) |=> full_o);

  a_r7_ovr_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !rel_wr_i && 32'(pend_cnt_o) == DEPTH) |=> (ovr_o && 32'(pend_cnt_o) == DEPTH));

  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_ovr_i) |=> ovr_o);

  a_r8_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && rel_wr_i && pend_cnt_o != 2'd0) |=> $stable(pend_cnt_o));

  a_r10_empty_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_cnt_o == 2'd0) |-> (head_frame_o == '0));
endmodule

bind rx_fifo_rel rx_fifo_rel_chk #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .rel_wr_i     (rel_wr_i),
  .clr_full_i   (clr_full_i),
  .clr_ovr_i    (clr_ovr_i),
  .head_frame_o (head_frame_o),
  .pend_cnt_o   (pend_cnt_o),
  .full_o       (full_o),
  .ovr_o        (ovr_o),
  .rel_o        (rel_o)
);

// File: tb/tb_rx_fifo_rel.sv
`timescale 1ns/1ps
module tb_rx_fifo_rel;
  localparam int FW    = 40;
  localparam int CAP   = 3;
  localparam int LIMIT = 5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0, rel = 1'b0, cfull = 1'b0, covr = 1'b0;
  logic [FW-1:0] frame = '0;
  logic [FW-1:0] head;
  logic [1:0]    cnt;
  logic          full, ovr, relb;
  logic [31:0]   regv;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [FW-1:0] q[$];
  bit m_full = 0, m_ovr = 0, m_rel = 0;
  logic [FW-1:0] seq = 40'h10_0000_0001;

  always #4 clk = ~clk;

  rx_fifo_rel #(.DEPTH(CAP), .FRAME_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_frame_i(frame),
    .rel_wr_i(rel), .clr_full_i(cfull), .clr_ovr_i(covr),
    .head_frame_o(head), .pend_cnt_o(cnt), .full_o(full), .ovr_o(ovr),
    .rel_o(relb), .reg_o(regv)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // full comparison against the model, every cycle
  task automatic compare();
    logic [FW-1:0] eh;
    logic [31:0]   er;
    eh = (q.size() != 0) ? q[0] : '0;
    er = 32'(q.size()) | (32'(m_full) << 3) | (32'(m_ovr) << 4) | (32'(m_rel) << 5);
    chk("R2 count", 64'(cnt), 64'(q.size()));
    chk("R3 head", 64'(head), 64'(eh));
    chk("R4 release bit", 64'(relb), 64'(m_rel));
    chk("R6 full", 64'(full), 64'(m_full));
    chk("R7 overrun", 64'(ovr), 64'(m_ovr));
    chk("R9 register view", 64'(regv), 64'(er));
  endtask

  task automatic step(input bit p, input bit r, input bit cf, input bit co);
    bit do_rel, acc;
    push = p; rel = r; cfull = cf; covr = co;
    frame = seq;
    @(posedge clk);
    do_rel = r && q.size() != 0;
    acc    = p && (q.size() < CAP || do_rel);
    if (do_rel) void'(q.pop_front());
    if (acc) q.push_back(seq);
    if (p && !acc) m_ovr = 1; else if (co) m_ovr = 0;
    if (acc && q.size() == CAP) m_full = 1; else if (cf) m_full = 0;
    m_rel = do_rel;
    if (p) seq = seq + 40'h01_0101_0101;
    @(negedge clk);
    push = 0; rel = 0; cfull = 0; covr = 0;
    compare();
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset count", 64'(cnt), 64'd0);
    chk("R1 reset reg", 64'(regv), 64'd0);
    chk("R1 reset head", 64'(head), 64'd0);
    // R5 release on empty, R10 zero head
    step(0, 1, 0, 0);
    chk("R5 empty release", 64'(relb), 64'd0);
    chk("R10 empty head", 64'(head), 64'd0);
    // R2 fill to three, R6 full sets
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R6 full at three", 64'(full), 64'd1);
    // R7 overrun drops frame
    step(1, 0, 0, 0);
    chk("R7 overrun count kept", 64'(cnt), 64'd3);
    // R7 set wins over clear
    step(1, 0, 0, 1);
    chk("R7 set beats clear", 64'(ovr), 64'd1);
    // R3/R4 release
    step(0, 1, 0, 0);
    chk("R4 pulse high", 64'(relb), 64'd1);
    step(0, 0, 0, 0);
    chk("R4 pulse gone", 64'(relb), 64'd0);
    chk("R6 full sticky", 64'(full), 64'd1);
    // R8 push+release mid-level
    step(1, 1, 0, 0);
    chk("R8 count held", 64'(cnt), 64'd2);
    step(1, 0, 1, 1);
    // R8 push+release at three sets full, not overrun
    step(1, 1, 0, 0);
    chk("R8 full at three", 64'(full), 64'd1);
    chk("R8 no overrun", 64'(ovr), 64'd0);
    // R6 set wins over clear
    step(1, 1, 1, 0);
    chk("R6 set beats clear", 64'(full), 64'd1);
    step(0, 0, 1, 0);
    // drain past pointer wrap
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    chk("R5 drained", 64'(cnt), 64'd0);
    step(0, 1, 0, 0);
    chk("R5 release ignored", 64'(relb), 64'd0);
    // push+release on empty: release ignored, push kept
    step(1, 1, 0, 0);
    chk("R5 push kept on empty release", 64'(cnt), 64'd1);
    for (int i = 0; i < 6; i++) step(i % 2 == 0, i % 3 == 0, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    chk("R10 head zero at end", 64'(head), 64'(q.size() != 0 ? q[0] : '0));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule